// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands one bit pair per clock, least significant pair first. Both operands sit in right-shifting registers. On each enabled step, the bit leaving the augend register and the bit leaving the addend register are combined with a stored carry. The resulting sum bit re-enters the augend register at its most significant end. After as many steps as the operand width, the augend register holds the sum and the carry flip-flop holds the carry out.

The carry is kept in a set/reset style flip-flop. It is set when both operand bits are 1, cleared when both are 0, and otherwise holds. A small sequencer takes a start request, counts the enabled steps and pulses done on the step that completes the add. The addend register has its own serial input, so a new operand can be streamed in while the old one is consumed. A parameter selects an alternative carry style, a plain register loaded with the majority function. Both styles give the same results.

Top module: `bitserial_adder`

## Requirements
- R1: A synchronous clear (srst high at a clock edge) empties both registers, clears the carry and leaves busy and done low.
- R2: A load while idle (busy low) copies opa into the augend register and opb into the addend register, and clears the carry.
- R3: After start, the operands are consumed least significant bit first. After WIDTH enabled steps, sum_q equals (opa + opb) mod 2^WIDTH.
- R4: When done is high, cout equals bit WIDTH of opa + opb.
- R5: A clock edge with shift_en low changes neither sum_q, addend_q nor cout, and does not advance the step count.
- R6: done is high for exactly one cycle. It follows the edge of the WIDTH-th enabled step, and busy is low from that edge on.
- R7: A start request while busy is ignored. The step count continues, and done arrives after WIDTH enabled steps counted from the accepted start.
- R8: During an add, serial_in enters addend_q at bit WIDTH-1. The first bit sent ends at bit 0 after WIDTH steps.
- R9: During an add, cout reflects the carry flip-flop. It becomes 1 after a step whose operand bits are both 1, becomes 0 after a step whose bits are both 0, and otherwise keeps its value.
- R10: A load while busy, and shift_en while idle, are ignored: sum_q and addend_q do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous clear, active high |
| load | input | 1 | Parallel load of both operands (idle only) |
| opa | input | WIDTH | Augend parallel input |
| opb | input | WIDTH | Addend parallel input |
| start | input | 1 | Begin an addition (idle only) |
| shift_en | input | 1 | Enables one step per clock while busy |
| serial_in | input | 1 | Serial input at the addend register's top end |
| sum_q | output | WIDTH | Augend/result register |
| addend_q | output | WIDTH | Addend register |
| cout | output | 1 | Carry flip-flop; the final carry when done is high |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse on completion |

## Verification
The hardest case to reach from the ports is a stray start request that lands in the middle of a stalled addition. To show that the count was not restarted, the request must coincide with an enabled step. The bench therefore pauses partway through an add, raises start together with shift_en for one step, and then gives exactly the remaining steps. It then expects done on the step that completes the WIDTH total. The carry's hold case is driven with operands whose low bits differ, so that cout must keep a 1 across a step.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
   typedef enum logic {
      CARRY_SETRESET = 1'b0,
      CARRY_MAJORITY = 1'b1
   } carry_style_e;
endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             ld,
   input  logic [WIDTH-1:0] ld_val,
   input  logic             step,
   input  logic             top_in,
   output logic [WIDTH-1:0] q,
   output logic             low_bit
);
   if (WIDTH < 2) begin : g_bad_width
      $error("bsa_shreg: WIDTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (clr)       q <= '0;
      else if (ld)   q <= ld_val;
      else if (step) q <= {top_in, q[WIDTH-1:1]};
   end

   assign low_bit = q[0];

   a_r3_shift_right: assert property (@(posedge clk) disable iff (clr)
      (step && !ld) |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1])));
endmodule

// File: rtl/bsa_carry.sv
module bsa_carry
   import bsa_pkg::*;
#(
   parameter carry_style_e STYLE = CARRY_SETRESET
) (
   input  logic clk,
   input  logic clr,
   input  logic en,
   input  logic x,
   input  logic y,
   output logic q
);
   if (STYLE == CARRY_SETRESET) begin : g_setreset
      logic set_c, rst_c;
      assign set_c = x & y;
      assign rst_c = ~x & ~y;
      always_ff @(posedge clk) begin
         if (clr) q <= 1'b0;
         else if (en) begin
            case ({set_c, rst_c})
               2'b10:   q <= 1'b1;
               2'b01:   q <= 1'b0;
               default: q <= q;
            endcase
         end
      end
   end else begin : g_majority
      always_ff @(posedge clk) begin
         if (clr)     q <= 1'b0;
         else if (en) q <= (x & y) | (q & (x | y));
      end
   end

   a_r9_carry_set: assert property (@(posedge clk) disable iff (clr)
      (en && x && y) |=> q);
   a_r9_carry_clear: assert property (@(posedge clk) disable iff (clr)
      (en && !x && !y) |=> !q);
   a_r9_carry_keep: assert property (@(posedge clk) disable iff (clr)
      (en && (x != y)) |=> $stable(q));
   a_r5_carry_idle: assert property (@(posedge clk) disable iff (clr)
      !en |=> $stable(q));
endmodule

// File: rtl/bsa_seq.sv
module bsa_seq #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic srst,
   input  logic start,
   input  logic shift_en,
   output logic busy,
   output logic done,
   output logic step
);
   localparam int CW = (WIDTH < 2) ? 1 : $clog2(WIDTH);
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   logic [CW-1:0] cnt;

   assign step = busy & shift_en;

   always_ff @(posedge clk) begin
      if (srst) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               cnt  <= '0;
            end
         end else if (shift_en) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   a_r6_done_single: assert property (@(posedge clk) disable iff (srst)
      done |=> !done);
   a_r6_done_idle: assert property (@(posedge clk) disable iff (srst)
      done |-> !busy);
   a_r7_start_ignored: assert property (@(posedge clk) disable iff (srst)
      (busy && start && !shift_en) |=> (busy && $stable(cnt)));
   a_r5_count_hold: assert property (@(posedge clk) disable iff (srst)
      (busy && !shift_en) |=> $stable(cnt));
endmodule

// File: rtl/bitserial_adder.sv
module bitserial_adder
   import bsa_pkg::*;
#(
   parameter int           WIDTH       = 8,
   parameter carry_style_e CARRY_STYLE = CARRY_SETRESET
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             load,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             start,
   input  logic             shift_en,
   input  logic             serial_in,
   output logic [WIDTH-1:0] sum_q,
   output logic [WIDTH-1:0] addend_q,
   output logic             cout,
   output logic             busy,
   output logic             done
);
   if (WIDTH < 2) begin : g_bad_width
      $error("bitserial_adder: WIDTH must be at least 2");
   end

   logic step, ld_ok, start_ok, carry_clr;
   logic xa, yb, sbit;

   assign ld_ok     = load & ~busy;
   assign start_ok  = start & ~busy;
   assign carry_clr = srst | ld_ok | start_ok;

   bsa_seq #(.WIDTH(WIDTH)) u_seq (
      .clk(clk), .srst(srst), .start(start), .shift_en(shift_en),
      .busy(busy), .done(done), .step(step)
   );

   bsa_shreg #(.WIDTH(WIDTH)) u_aug (
      .clk(clk), .clr(srst), .ld(ld_ok), .ld_val(opa), .step(step),
      .top_in(sbit), .q(sum_q), .low_bit(xa)
   );

   bsa_shreg #(.WIDTH(WIDTH)) u_add (
      .clk(clk), .clr(srst), .ld(ld_ok), .ld_val(opb), .step(step),
      .top_in(serial_in), .q(addend_q), .low_bit(yb)
   );

   bsa_carry #(.STYLE(CARRY_STYLE)) u_cy (
      .clk(clk), .clr(carry_clr), .en(step), .x(xa), .y(yb), .q(cout)
   );

   assign sbit = xa ^ yb ^ cout;

   a_r5_hold_all: assert property (@(posedge clk) disable iff (srst)
      (!step && !ld_ok && !start_ok) |=> ($stable(sum_q) && $stable(addend_q) && $stable(cout)));
   a_r2_load_clears_carry: assert property (@(posedge clk) disable iff (srst)
      ld_ok |=> (!cout && sum_q == $past(opa) && addend_q == $past(opb)));
   a_r8_serial_top: assert property (@(posedge clk) disable iff (srst)
      step |=> (addend_q[WIDTH-1] == $past(serial_in)));
   a_r10_load_busy: assert property (@(posedge clk) disable iff (srst)
      (busy && !shift_en) |=> ($stable(sum_q) && $stable(addend_q)));
endmodule

// File: tb/tb_bitserial_adder.sv
`timescale 1ns/1ps
module tb_bitserial_adder;
   localparam int W = 8;

   logic clk = 1'b0;
   logic srst, load, start, shift_en, serial_in;
   logic [W-1:0] opa, opb;
   logic [W-1:0] sum_q, addend_q;
   logic cout, busy, done;
   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   bitserial_adder #(.WIDTH(W)) dut (
      .clk(clk), .srst(srst), .load(load), .opa(opa), .opb(opb),
      .start(start), .shift_en(shift_en), .serial_in(serial_in),
      .sum_q(sum_q), .addend_q(addend_q), .cout(cout), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
      opa = a; opb = b; load = 1'b1; tick(); load = 1'b0;
   endtask

   task automatic do_start();
      start = 1'b1; tick(); start = 1'b0;
   endtask

   task automatic steps(input int n);
      shift_en = 1'b1;
      repeat (n) tick();
      shift_en = 1'b0;
   endtask

   task automatic t_reset();
      srst = 1'b1; tick(); tick(); srst = 1'b0;
      chk(sum_q == 0 && addend_q == 0, "R1 regs", {sum_q, addend_q}, 0);
      chk(!cout && !busy && !done, "R1 flags", {cout, busy, done}, 0);
   endtask

   task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0] full;
      full = {1'b0, a} + {1'b0, b};
      do_load(a, b);
      chk(sum_q == a && addend_q == b && !cout, "R2 load", {sum_q, addend_q}, {a, b});
      do_start();
      chk(busy, "R6 busy after start", busy, 1);
      steps(W);
      chk(sum_q == full[W-1:0], "R3 sum", sum_q, full[W-1:0]);
      chk(cout == full[W], "R4 carry out", cout, full[W]);
      chk(done && !busy, "R6 done", {done, busy}, 2'b10);
      tick();
      chk(!done, "R6 done one cycle", done, 0);
   endtask

   task automatic t_stall();
      logic [W-1:0] snap;
      do_load(8'h6B, 8'h3D);
      do_start();
      steps(3);
      snap = sum_q;
      repeat (4) tick();
      chk(sum_q == snap && busy && !done, "R5 stall holds", sum_q, snap);
      steps(W - 3);
      chk(done && sum_q == 8'hA8 && !cout, "R5 stall result", sum_q, 8'hA8);
   endtask

   task automatic t_start_busy();
      do_load(8'h81, 8'h82);
      do_start();
      steps(4);
      start = 1'b1; steps(1); start = 1'b0;
      chk(busy && !done, "R7 still busy", busy, 1);
      steps(W - 5);
      chk(done && sum_q == 8'h03 && cout, "R7 done on time", {done, sum_q}, {1'b1, 8'h03});
   endtask

   task automatic t_serial();
      logic [W-1:0] pat;
      pat = 8'hC5;
      do_load(8'h00, 8'h00);
      do_start();
      shift_en = 1'b1;
      for (int i = 0; i < W; i++) begin
         serial_in = pat[i];
         tick();
      end
      shift_en = 1'b0; serial_in = 1'b0;
      chk(addend_q == pat, "R8 serial fill", addend_q, pat);
   endtask

   task automatic t_carry();
      do_load(8'h03, 8'h01);
      do_start();
      steps(1);
      chk(cout, "R9 set", cout, 1);
      steps(1);
      chk(cout, "R9 keep", cout, 1);
      steps(1);
      chk(!cout, "R9 clear", cout, 0);
      steps(W - 3);
      chk(sum_q == 8'h04, "R9 sum", sum_q, 8'h04);
   endtask

   task automatic t_ignore();
      logic [W-1:0] s, d;
      do_load(8'h10, 8'h22);
      do_start();
      steps(2);
      s = sum_q; d = addend_q;
      do_load(8'hFF, 8'hFF);
      chk(sum_q == s && addend_q == d, "R10 load while busy", sum_q, s);
      steps(W - 2);
      chk(sum_q == 8'h32, "R10 sum unaffected", sum_q, 8'h32);
      s = sum_q; d = addend_q;
      steps(3);
      chk(sum_q == s && addend_q == d && !busy, "R10 shift while idle", sum_q, s);
   endtask

   initial begin
      srst = 1'b0; load = 1'b0; start = 1'b0; shift_en = 1'b0; serial_in = 1'b0;
      opa = '0; opb = '0;
      tick();
      t_reset();
      t_add(8'h5A, 8'h33);
      t_add(8'hFF, 8'h01);
      t_add(8'h00, 8'h00);
      t_add(8'hFF, 8'hFF);
      t_stall();
      t_start_busy();
      t_serial();
      t_carry();
      t_ignore();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #40000;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule